// File: doc/BRIEF.md
# Shared Bus-Strobe Pin Function Selector

This block computes the level driven onto one port pin that three functions of an external bus interface share. The pin can carry an active-low data-bus enable strobe, which the external bus uses as its drive enable on reads in expanded modes. It can carry an inverted copy of the E clock, which external logic uses to latch a multiplexed address. It can also carry a calibration clock from a programmable divider with 50% duty. When none of these is selected, the pin carries a general-purpose output bit.

The E clock is made inside the block by dividing the system clock by four. Each E period therefore has four phases, and E is high in phases 2 and 3. A bus cycle may be stretched over several E periods. In that case the strobe fires only in the last quarter of the final period.

Configuration bits pass to the pin only at E-period boundaries, so a change never cuts a phase short. The divided slow clock is also brought out on its own output.

Top module: `bus_strobe_pin_mux`

## Requirements
- R1: While `rst_ni` is low, `pin_o` equals `gpo_i`.
- R2: In E-period phase p (p = 0,1,2,3, counted from 0 at reset release and advancing once per `clk_i`), E is high for p = 2 and 3. When the strobe function is active, a bus cycle with stretch 0 drives `pin_o` low in exactly phases 2 and 3, and high in phases 0 and 1.
- R3: `stretch_i` is sampled at the boundary that starts a bus cycle. A cycle with stretch S lasts S+1 E periods. For S > 0 the strobe is low only in phase 3 of the last of those periods. The first bus cycle after reset has stretch 0.
- R4: With `expanded_i`=1, `strb_dis_i`=0 and `strb_alt_i`=1 in effect, `pin_o` is the inverted E clock: low in phases 2 and 3, high in phases 0 and 1.
- R5: The two strobe functions are available only with `expanded_i`=1 and `strb_dis_i`=0. They take priority over calibration. Otherwise, with `cal_en_i`=1, `pin_o` equals `slow_clk_o`.
- R6: Let h = `div_ratio_i` >> 1. If h = 0 (ratio 0 or 1, the reset value), `slow_clk_o` follows `clk_i`. Otherwise it toggles every h clocks, so its high and low times are each h clocks.
- R7: When no pin function is in effect, `pin_o` follows `gpo_i` combinationally.
- R8: `expanded_i`, `strb_dis_i`, `strb_alt_i` and `cal_en_i` are captured only at the clock edge that ends phase 3. Changes at other times have no effect on `pin_o` until that edge. The reset state of the captured copies is all zero, so the pin carries `gpo_i` until the first boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| expanded_i | input | 1 | Expanded bus mode |
| strb_dis_i | input | 1 | Disable both strobe functions |
| strb_alt_i | input | 1 | Select inverted E clock instead of data strobe |
| cal_en_i | input | 1 | Enable calibration clock on the pin |
| gpo_i | input | 1 | General-purpose output data bit |
| stretch_i | input | STW | Extra E periods for the next bus cycle |
| div_ratio_i | input | DW | Slow-clock divide ratio (even; 0 bypasses) |
| pin_o | output | 1 | Shared pin level |
| slow_clk_o | output | 1 | Divided slow clock |

## Verification
The bench goes after stretched cycles, where a strobe that fired in every stretch period, or over the whole E-high half of the final period, would enable the external drivers too early. It changes configuration in the middle of E periods, so a selector that applied changes at once would switch the pin partway through a phase. Calibration is enabled together with the strobe to show strobe priority, and calibration is tested outside expanded mode. The divider is checked at small, large and bypass ratios, where an off-by-one in the terminal count shows up as unequal high and low times.

// File: rtl/pin_mux_pkg.sv
package pin_mux_pkg;
  typedef enum logic [1:0] {
    FN_GPO    = 2'd0,
    FN_STRB   = 2'd1,
    FN_ECLK_N = 2'd2,
    FN_CAL    = 2'd3
  } pin_fn_e;

  typedef struct packed {
    logic exp;
    logic dis;
    logic alt;
    logic cal_en;
  } pin_cfg_t;
endpackage

// File: rtl/strobe_phase_gen.sv
module strobe_phase_gen #(
  parameter int STW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [STW-1:0] stretch_i,
  output logic [1:0]     phase_o,
  output logic           bound_o,
  output logic           e_hi_o,
  output logic           last_per_o,
  output logic           stretched_o
);
  logic [1:0]     phase_q;
  logic [STW-1:0] left_q;
  logic           str_q;

  assign bound_o     = (phase_q == 2'd3);
  assign e_hi_o      = phase_q[1];
  assign last_per_o  = (left_q == '0);
  assign stretched_o = str_q;
  assign phase_o     = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 2'd0;
      left_q  <= '0;
      str_q   <= 1'b0;
    end else begin
      phase_q <= phase_q + 2'd1;
      if (bound_o) begin
        if (left_q == '0) begin
          // new bus cycle: take stretch for its whole span
          left_q <= stretch_i;
          str_q  <= |stretch_i;
        end else begin
          left_q <= left_q - 1'b1;
        end
      end
    end
  end

  // R2
  phase_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == 2'd3) |=> (phase_q == 2'd0));

  // R3
  stretch_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bound_o && left_q != '0) |=> (left_q == $past(left_q) - 1'b1));

  // R3
  stretch_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bound_o && left_q == '0) |=> $stable(str_q));
endmodule

// File: rtl/slow_clk_div.sv
module slow_clk_div #(
  parameter int DW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] ratio_i,
  output logic          slow_o
);
  localparam int HW = DW - 1;

  logic [HW-1:0] half;
  logic [HW-1:0] cnt_q;
  logic          div_q;
  logic          bypass;

  assign half   = ratio_i[DW-1:1];
  assign bypass = (half == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (bypass) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (cnt_q >= half - 1'b1) begin
      cnt_q <= '0;
      div_q <= ~div_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign slow_o = bypass ? clk_i : div_q;

  // R6
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass && cnt_q < half - 1'b1) |=> $stable(div_q));

  // R6
  div_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |=> !div_q);
endmodule

// File: rtl/pin_fn_sel.sv
module pin_fn_sel
  import pin_mux_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bound_i,
  input  pin_cfg_t cfg_i,
  output pin_fn_e  fn_o
);
  pin_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (bound_i) cfg_q <= cfg_i;
  end

  // strobe variants outrank calibration, calibration outranks gpo
  always_comb begin
    if (cfg_q.exp && !cfg_q.dis) fn_o = cfg_q.alt ? FN_ECLK_N : FN_STRB;
    else if (cfg_q.cal_en)       fn_o = FN_CAL;
    else                         fn_o = FN_GPO;
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bound_i |=> $stable(cfg_q));
endmodule

// File: rtl/bus_strobe_pin_mux.sv
module bus_strobe_pin_mux
  import pin_mux_pkg::*;
#(
  parameter int STW = 3,
  parameter int DW  = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           expanded_i,
  input  logic           strb_dis_i,
  input  logic           strb_alt_i,
  input  logic           cal_en_i,
  input  logic           gpo_i,
  input  logic [STW-1:0] stretch_i,
  input  logic [DW-1:0]  div_ratio_i,
  output logic           pin_o,
  output logic           slow_clk_o
);
  logic [1:0] phase;
  logic       bound, e_hi, last_per, stretched;
  logic       strb_n;
  pin_cfg_t   cfg;
  pin_fn_e    fn;

  strobe_phase_gen #(.STW(STW)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stretch_i  (stretch_i),
    .phase_o    (phase),
    .bound_o    (bound),
    .e_hi_o     (e_hi),
    .last_per_o (last_per),
    .stretched_o(stretched)
  );

  slow_clk_div #(.DW(DW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ratio_i(div_ratio_i),
    .slow_o (slow_clk_o)
  );

  assign cfg = '{exp: expanded_i, dis: strb_dis_i, alt: strb_alt_i, cal_en: cal_en_i};

  pin_fn_sel u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bound_i(bound),
    .cfg_i  (cfg),
    .fn_o   (fn)
  );

  // stretched cycles: last quarter of final period only
  assign strb_n = !(e_hi && last_per && (!stretched || phase == 2'd3));

  always_comb begin
    unique case (fn)
      FN_STRB:   pin_o = strb_n;
      FN_ECLK_N: pin_o = !e_hi;
      FN_CAL:    pin_o = slow_clk_o;
      default:   pin_o = gpo_i;
    endcase
  end

  // R2
  strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn == FN_STRB && !e_hi) |-> pin_o);

  // R3
  strobe_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn == FN_STRB && !last_per) |-> pin_o);

  // R4
  eclk_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn == FN_ECLK_N) |-> (pin_o == !e_hi));

  // R5
  cal_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn == FN_CAL) |-> (pin_o == slow_clk_o));
endmodule

// File: tb/tb_bus_strobe_pin_mux.sv
module tb_bus_strobe_pin_mux;
  localparam int STW = 3;
  localparam int DW  = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           expanded = 1'b1, strb_dis = 1'b0, strb_alt = 1'b0, cal_en = 1'b0;
  logic           gpo = 1'b0;
  logic [STW-1:0] stretch = '0;
  logic [DW-1:0]  ratio = '0;
  logic           pin, slow;

  int n_chk = 0, n_bad = 0;
  bit run_chk = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  bus_strobe_pin_mux #(.STW(STW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .expanded_i(expanded), .strb_dis_i(strb_dis),
    .strb_alt_i(strb_alt), .cal_en_i(cal_en), .gpo_i(gpo), .stretch_i(stretch),
    .div_ratio_i(ratio), .pin_o(pin), .slow_clk_o(slow)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // requirement model
  int m_ph, m_left;
  bit m_exp, m_dis, m_alt, m_cal, m_str;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_left <= 0; m_str <= 0;
      m_exp <= 0; m_dis <= 0; m_alt <= 0; m_cal <= 0;
    end else begin
      if (m_ph == 3) begin
        m_exp <= expanded; m_dis <= strb_dis; m_alt <= strb_alt; m_cal <= cal_en;
        if (m_left == 0) begin
          m_left <= int'(stretch);
          m_str  <= (stretch != 0);
        end else m_left <= m_left - 1;
      end
      m_ph <= (m_ph + 1) % 4;
    end
  end

  function automatic bit exp_pin(output string tag);
    bit e_hi = (m_ph >= 2);
    bit pend = (expanded != m_exp) || (strb_dis != m_dis) ||
               (strb_alt != m_alt) || (cal_en != m_cal);
    if (m_exp && !m_dis && !m_alt) begin
      tag = m_str ? "R3" : "R2";
      exp_pin = !(e_hi && m_left == 0 && (!m_str || m_ph == 3));
    end else if (m_exp && !m_dis) begin
      tag = "R4"; exp_pin = !e_hi;
    end else if (m_cal) begin
      tag = "R5"; exp_pin = slow;
    end else begin
      tag = "R7"; exp_pin = gpo;
    end
    if (pend) tag = "R8";
  endfunction

  int last_ratio = 0, skip = 2, run = 0;
  bit prev_slow = 1'b0;

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      string tag;
      bit e;
      int h;
      e = exp_pin(tag);
      check(pin == e, tag, int'(pin), int'(e));
      h = int'(ratio) >> 1;
      if (int'(ratio) != last_ratio || h == 0) begin
        skip = 2; run = 0; last_ratio = int'(ratio);
      end
      if (h == 0) begin
        check(slow == 1'b0, "R6", int'(slow), 0);
      end else if (slow != prev_slow) begin
        if (skip == 0) check(run == h, "R6", run, h);
        else skip--;
        run = 1;
      end else run++;
      prev_slow = slow;
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n && run_chk && (int'(ratio) >> 1) == 0)
      check(slow == 1'b1, "R6", int'(slow), 1);
  end

  task automatic cycles(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      gpo = 1'($urandom);
      if (rnd) begin
        stretch = STW'($urandom);
        if ($urandom % 16 == 0) begin
          expanded = 1'($urandom); strb_dis = 1'($urandom);
          strb_alt = 1'($urandom); cal_en   = 1'($urandom);
        end
        if ($urandom % 200 == 0) ratio = DW'(2 * ($urandom % 11));
      end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset drives gpo onto the pin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1 gpo = i[0];
      #2 check(pin == gpo, "R1", int'(pin), int'(gpo));
    end
    @(negedge clk);
    #1 rst_n = 1'b1;
    run_chk = 1'b1;
    cycles(40, 0);                          // R2, R8 first-boundary
    stretch = 3'd2; cycles(48, 0);          // R3
    stretch = 3'd1; cycles(24, 0);
    stretch = 3'd7; cycles(64, 0);
    stretch = 3'd0; cal_en = 1'b1; cycles(24, 0);  // R5 priority
    strb_alt = 1'b1; cycles(24, 0);         // R4
    strb_alt = 1'b0; strb_dis = 1'b1;
    ratio = 6'd6;  cycles(120, 0);          // R6
    ratio = 6'd0;  cycles(40, 0);
    ratio = 6'd40; cycles(240, 0);
    ratio = 6'd3;  cycles(40, 0);
    expanded = 1'b0; strb_dis = 1'b0; ratio = 6'd4; cycles(40, 0);
    cal_en = 1'b0; cycles(32, 0);           // R7
    expanded = 1'b1; cycles(32, 0);
    cycles(12000, 1);                       // random incl. mid-period changes (R8)
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule